// File: doc/BRIEF.md
# Camera Receiver Error Status and Control Register Bank

This block is the register bank of a camera serial receive controller. It is an APB slave that holds the lane-count setting and three active-low reset controls. It also passes the live PHY lane state through to software and drives the port used to program the PHY's test registers. Its main job is error collection. Single-cycle error pulses arrive from the lane merger, the packet header ECC decoder and the frame/line sequence checker. The bank latches each pulse into a sticky bit, which stays set until software reads the status word that holds it.

There are two status words, and each has a mask word beside it. The interrupt output is a level that stays high while any status bit is set and its mask bit is clear. Software services the interrupt by reading a status word. That read returns the collected bits and clears them, unless an event for a bit lands on the same cycle. The lane-count field is protected: a write to it takes effect only while all four data lanes report the stop state.

APB timing: a transfer has a setup cycle (`psel` high, `penable` low) followed by an access cycle (`psel` and `penable` both high). A write takes effect at the clock edge that ends the access cycle. Read data is valid during the access cycle. A status read clears the word at that same edge. Every transfer completes in two cycles. There are no wait states and no error response.

Top module: `camrx_csr_bank`

## Requirements
- R1: Reset values: lane count 2'b01, the three reset controls 0, masks 0, status 0, test strobe, clear, enable and data 0, and the interrupt low.
- R2: Bit 0 of offset 0x08 drives `phy_shutdown_n_o`, bit 0 of 0x0C drives `phy_reset_n_o` and bit 0 of 0x10 drives `ctrl_reset_n_o`. All three read back at bit 0.
- R3: Offset 0x04 bits 1:0 hold the lane count (00 = one lane up to 11 = four lanes). A write updates the field only if `phy_state_i[7:4]` is 4'hF in the access cycle. Otherwise the field keeps its value.
- R4: A read of offset 0x14 returns `phy_state_i[10:0]` in bits 10:0. Bits 31:11 read as zero.
- R5: An event pulse on `err1_evt_i[b]` sets status word 1 bit b (offset 0x20, bits 28:0), and `err2_evt_i[b]` sets status word 2 bit b (offset 0x24, bits 23:0). A set bit stays set until that word is read. Writes to 0x20 and 0x24 have no effect.
- R6: A read of a status word returns its current bits and clears the word at the access edge. A bit whose event arrives in the same access cycle stays set.
- R7: `irq_o` is high exactly when some status bit is set and the matching mask bit is 0. Mask word 1 is at 0x28 (bits 28:0) and mask word 2 is at 0x2C (bits 23:0). An event sampled at an edge is visible on `irq_o` right after that edge.
- R8: Offset 0x30 bit 1 drives `test_strobe_o` and bit 0 drives `test_clear_o` (active high). Both read back.
- R9: Offset 0x34 bit 16 drives `test_addr_sel_o` (1: address write on the strobe's falling edge, 0: data write on its rising edge). Bits 7:0 drive `test_din_o`. Bits 15:8 read `test_dout_i`.
- R10: Reserved bits read as zero and ignore writes. Unmapped offsets, and addresses with any bit above bit 7 set, read as zero and change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus and register clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| psel_i | input | 1 | APB select |
| penable_i | input | 1 | APB access phase |
| pwrite_i | input | 1 | APB direction, 1 = write |
| paddr_i | input | ADDR_W | APB byte address |
| pwdata_i | input | 32 | APB write data |
| prdata_o | output | 32 | APB read data, valid in the access cycle |
| phy_state_i | input | 11 | Live PHY clock-lane and data-lane state |
| err1_evt_i | input | 29 | Error event pulses for status word 1 |
| err2_evt_i | input | 24 | Error event pulses for status word 2 |
| test_dout_i | input | 8 | PHY test port read-back data |
| lane_count_o | output | 2 | Active data lane count code |
| phy_shutdown_n_o | output | 1 | PHY shutdown, active low |
| phy_reset_n_o | output | 1 | PHY reset, active low |
| ctrl_reset_n_o | output | 1 | Controller reset, active low |
| test_strobe_o | output | 1 | PHY test port strobe |
| test_clear_o | output | 1 | PHY test port clear, active high |
| test_addr_sel_o | output | 1 | PHY test port address/data select |
| test_din_o | output | 8 | PHY test port write data |
| irq_o | output | 1 | Level interrupt |

## Verification
The embedded properties check the sticky behaviour on every cycle: an event always leaves its bit set, a bit never drops except on a status read, and a read with no coincident event empties the word. They also check that a blocked lane-count write never moves the field, and that an unmasked event always raises the interrupt. Only the bench scenarios can show the address decode, the exact read-data layout of each offset, the loss of nothing when an event coincides with a read, and that unmapped or reserved writes leave the visible state untouched. These scenarios combine random event, mask and read traffic with directed cases.

// File: rtl/camrx_csr_pkg.sv
package camrx_csr_pkg;
  localparam int DATA_W  = 32;
  localparam int ST1_W   = 29;
  localparam int ST2_W   = 24;
  localparam int PHYST_W = 11;
  localparam int TDATA_W = 8;
  localparam int LANE_W  = 2;
  localparam int NLANES  = 4;
  localparam int STOP_LO = 4;   // data-lane stop flags start here in the PHY state word
  localparam int TEN_BIT = 16;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_LANES, SEL_SHUT, SEL_PRST, SEL_CRST, SEL_PHYST,
    SEL_ST1, SEL_ST2, SEL_MSK1, SEL_MSK2, SEL_TST0, SEL_TST1
  } csr_sel_e;

  function automatic csr_sel_e decode_offset(input logic [7:0] off);
    case (off)
      8'h04:   return SEL_LANES;
      8'h08:   return SEL_SHUT;
      8'h0C:   return SEL_PRST;
      8'h10:   return SEL_CRST;
      8'h14:   return SEL_PHYST;
      8'h20:   return SEL_ST1;
      8'h24:   return SEL_ST2;
      8'h28:   return SEL_MSK1;
      8'h2C:   return SEL_MSK2;
      8'h30:   return SEL_TST0;
      8'h34:   return SEL_TST1;
      default: return SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/camrx_sticky_word.sv
module camrx_sticky_word #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] evt_i,
  input  logic         rd_clr_i,
  input  logic         mask_we_i,
  input  logic [W-1:0] mask_wdata_i,
  output logic [W-1:0] status_o,
  output logic [W-1:0] mask_o,
  output logic         pend_o
);
  logic [W-1:0] live;

  // Per-bit sticky cell: a new event wins over a clear.
  for (genvar b = 0; b < W; b++) begin : g_cell
    logic bit_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       bit_q <= 1'b0;
      else if (evt_i[b]) bit_q <= 1'b1;
      else if (rd_clr_i) bit_q <= 1'b0;
    end
    assign status_o[b] = bit_q;
    assign live[b]     = bit_q & ~mask_o[b];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        mask_o <= '0;
    else if (mask_we_i) mask_o <= mask_wdata_i;
  end

  assign pend_o = |live;

  p_evt_sets_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i != '0) |=> ((status_o & $past(evt_i)) == $past(evt_i)));
  p_no_drop_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_clr_i |=> ((status_o & $past(status_o)) == $past(status_o)));
  p_rd_clears_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_clr_i && evt_i == '0) |=> (status_o == '0));
  p_mask_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mask_we_i |=> $stable(mask_o));
endmodule

// File: rtl/camrx_ctrl_regs.sv
module camrx_ctrl_regs
  import camrx_csr_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_lanes_i,
  input  logic               we_shut_i,
  input  logic               we_prst_i,
  input  logic               we_crst_i,
  input  logic               we_tst0_i,
  input  logic               we_tst1_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic [NLANES-1:0]  lane_stop_i,
  output logic [LANE_W-1:0]  lane_count_o,
  output logic               shut_n_o,
  output logic               prst_n_o,
  output logic               crst_n_o,
  output logic               strobe_o,
  output logic               clear_o,
  output logic               addr_sel_o,
  output logic [TDATA_W-1:0] din_o
);
  logic all_stopped;
  assign all_stopped = &lane_stop_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lane_count_o <= LANE_W'(1);
      shut_n_o     <= 1'b0;
      prst_n_o     <= 1'b0;
      crst_n_o     <= 1'b0;
      strobe_o     <= 1'b0;
      clear_o      <= 1'b0;
      addr_sel_o   <= 1'b0;
      din_o        <= '0;
    end else begin
      if (we_lanes_i && all_stopped) lane_count_o <= wdata_i[LANE_W-1:0];
      if (we_shut_i) shut_n_o <= wdata_i[0];
      if (we_prst_i) prst_n_o <= wdata_i[0];
      if (we_crst_i) crst_n_o <= wdata_i[0];
      if (we_tst0_i) begin
        strobe_o <= wdata_i[1];
        clear_o  <= wdata_i[0];
      end
      if (we_tst1_i) begin
        addr_sel_o <= wdata_i[TEN_BIT];
        din_o      <= wdata_i[TDATA_W-1:0];
      end
    end
  end

  p_lane_gate_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_lanes_i && !all_stopped) |=> $stable(lane_count_o));
  p_lane_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_lanes_i |=> $stable(lane_count_o));
  p_shut_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_shut_i |=> $stable(shut_n_o));
endmodule

// File: rtl/camrx_csr_bank.sv
module camrx_csr_bank
  import camrx_csr_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 psel_i,
  input  logic                 penable_i,
  input  logic                 pwrite_i,
  input  logic [ADDR_W-1:0]    paddr_i,
  input  logic [DATA_W-1:0]    pwdata_i,
  output logic [DATA_W-1:0]    prdata_o,
  input  logic [PHYST_W-1:0]   phy_state_i,
  input  logic [ST1_W-1:0]     err1_evt_i,
  input  logic [ST2_W-1:0]     err2_evt_i,
  input  logic [TDATA_W-1:0]   test_dout_i,
  output logic [LANE_W-1:0]    lane_count_o,
  output logic                 phy_shutdown_n_o,
  output logic                 phy_reset_n_o,
  output logic                 ctrl_reset_n_o,
  output logic                 test_strobe_o,
  output logic                 test_clear_o,
  output logic                 test_addr_sel_o,
  output logic [TDATA_W-1:0]   test_din_o,
  output logic                 irq_o
);
  localparam int HI_W = ADDR_W - 8;

  csr_sel_e sel;
  logic     access, wr, rd;
  logic [ST1_W-1:0] st1, msk1;
  logic [ST2_W-1:0] st2, msk2;
  logic pend1, pend2;

  always_comb begin
    sel = decode_offset(paddr_i[7:0]);
    if (paddr_i[ADDR_W-1:8] != HI_W'(0)) sel = SEL_NONE;
  end

  assign access = psel_i & penable_i;
  assign wr     = access & pwrite_i;
  assign rd     = access & ~pwrite_i;

  camrx_ctrl_regs u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .we_lanes_i   (wr && sel == SEL_LANES),
    .we_shut_i    (wr && sel == SEL_SHUT),
    .we_prst_i    (wr && sel == SEL_PRST),
    .we_crst_i    (wr && sel == SEL_CRST),
    .we_tst0_i    (wr && sel == SEL_TST0),
    .we_tst1_i    (wr && sel == SEL_TST1),
    .wdata_i      (pwdata_i),
    .lane_stop_i  (phy_state_i[STOP_LO+NLANES-1:STOP_LO]),
    .lane_count_o (lane_count_o),
    .shut_n_o     (phy_shutdown_n_o),
    .prst_n_o     (phy_reset_n_o),
    .crst_n_o     (ctrl_reset_n_o),
    .strobe_o     (test_strobe_o),
    .clear_o      (test_clear_o),
    .addr_sel_o   (test_addr_sel_o),
    .din_o        (test_din_o)
  );

  camrx_sticky_word #(.W(ST1_W)) u_word1 (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .evt_i        (err1_evt_i),
    .rd_clr_i     (rd && sel == SEL_ST1),
    .mask_we_i    (wr && sel == SEL_MSK1),
    .mask_wdata_i (pwdata_i[ST1_W-1:0]),
    .status_o     (st1),
    .mask_o       (msk1),
    .pend_o       (pend1)
  );

  camrx_sticky_word #(.W(ST2_W)) u_word2 (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .evt_i        (err2_evt_i),
    .rd_clr_i     (rd && sel == SEL_ST2),
    .mask_we_i    (wr && sel == SEL_MSK2),
    .mask_wdata_i (pwdata_i[ST2_W-1:0]),
    .status_o     (st2),
    .mask_o       (msk2),
    .pend_o       (pend2)
  );

  assign irq_o = pend1 | pend2;

  always_comb begin
    prdata_o = '0;
    if (rd) begin
      unique case (sel)
        SEL_LANES: prdata_o[LANE_W-1:0]  = lane_count_o;
        SEL_SHUT:  prdata_o[0]           = phy_shutdown_n_o;
        SEL_PRST:  prdata_o[0]           = phy_reset_n_o;
        SEL_CRST:  prdata_o[0]           = ctrl_reset_n_o;
        SEL_PHYST: prdata_o[PHYST_W-1:0] = phy_state_i;
        SEL_ST1:   prdata_o[ST1_W-1:0]   = st1;
        SEL_ST2:   prdata_o[ST2_W-1:0]   = st2;
        SEL_MSK1:  prdata_o[ST1_W-1:0]   = msk1;
        SEL_MSK2:  prdata_o[ST2_W-1:0]   = msk2;
        SEL_TST0:  prdata_o[1:0]         = {test_strobe_o, test_clear_o};
        SEL_TST1:  prdata_o[TEN_BIT:0]   = {test_addr_sel_o, test_dout_i, test_din_o};
        default:   prdata_o              = '0;
      endcase
    end
  end

  p_irq_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st1 == '0 && st2 == '0) |-> !irq_o);
  p_irq_rise_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (((err1_evt_i & ~msk1) != '0) && !(wr && sel == SEL_MSK1)) |=> irq_o);
  p_idle_bus_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !access |-> (prdata_o == '0));
endmodule

// File: tb/tb_camrx_csr_bank.sv
`timescale 1ns/1ps
module tb_camrx_csr_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        psel = 0, penable = 0, pwrite = 0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic [10:0] phy_st = '0;
  logic [28:0] ev1 = '0;
  logic [23:0] ev2 = '0;
  logic [7:0]  tdout = '0;
  logic [1:0]  lanes;
  logic        shut_n, prst_n, crst_n, strobe, clr, asel, irq;
  logic [7:0]  tdin;

  int checks = 0, failures = 0;
  bit done = 0;
  logic [28:0] s1 = '0, m1 = '0;
  logic [23:0] s2 = '0, m2 = '0;

  always #2 clk = ~clk;

  camrx_csr_bank dut (
    .clk_i(clk), .rst_ni(rst_n), .psel_i(psel), .penable_i(penable),
    .pwrite_i(pwrite), .paddr_i(paddr), .pwdata_i(pwdata), .prdata_o(prdata),
    .phy_state_i(phy_st), .err1_evt_i(ev1), .err2_evt_i(ev2),
    .test_dout_i(tdout), .lane_count_o(lanes), .phy_shutdown_n_o(shut_n),
    .phy_reset_n_o(prst_n), .ctrl_reset_n_o(crst_n), .test_strobe_o(strobe),
    .test_clear_o(clr), .test_addr_sel_o(asel), .test_din_o(tdin), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  function automatic logic exp_irq();
    return ((s1 & ~m1) != '0) || ((s2 & ~m2) != '0);
  endfunction

  task automatic apb_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); psel = 1; pwrite = 1; penable = 0; paddr = a; pwdata = d;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
  endtask

  // read with optional events applied in the access cycle
  task automatic apb_rd(input logic [11:0] a, input logic [28:0] e1,
                        input logic [23:0] e2, output logic [31:0] d);
    @(negedge clk); psel = 1; pwrite = 0; penable = 0; paddr = a;
    @(negedge clk); penable = 1; ev1 = e1; ev2 = e2;
    #1 d = prdata;
    @(negedge clk); psel = 0; penable = 0; ev1 = '0; ev2 = '0;
  endtask

  task automatic pulse(input logic [28:0] e1, input logic [23:0] e2);
    @(negedge clk); ev1 = e1; ev2 = e2;
    @(negedge clk); ev1 = '0; ev2 = '0;
    s1 |= e1; s2 |= e2;
  endtask

  task automatic read_status(input bit second, input logic [28:0] e1, input logic [23:0] e2);
    logic [31:0] d;
    apb_rd(second ? 12'h024 : 12'h020, e1, e2, d);
    if (!second) begin
      chk("R6 status1 read", d, {3'b0, s1});
      s1 = e1; s2 |= e2;
    end else begin
      chk("R6 status2 read", d, {8'b0, s2});
      s2 = e2; s1 |= e1;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'h5eed1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 lane count", 32'(lanes), 32'h1);
    chk("R1 resets", {29'b0, shut_n, prst_n, crst_n}, 32'h0);
    chk("R1 test port", {22'b0, strobe, clr, asel, tdin}, 32'h0);
    chk("R1 irq", 32'(irq), 32'h0);
    apb_rd(12'h028, '0, '0, d); chk("R1 mask1", d, 32'h0);

    // R2 reset controls, reserved bits dropped (R10)
    apb_wr(12'h008, 32'hFFFF_FFFF); apb_wr(12'h00C, 32'h1); apb_wr(12'h010, 32'hFFFF_FFFE);
    chk("R2 outputs", {29'b0, shut_n, prst_n, crst_n}, 32'h6);
    apb_rd(12'h008, '0, '0, d); chk("R2 R10 shutdown readback", d, 32'h1);
    apb_rd(12'h010, '0, '0, d); chk("R2 ctrl reset readback", d, 32'h0);

    // R3 lane-count gate
    phy_st = 11'h0F0;
    apb_wr(12'h004, 32'h3); chk("R3 gated open", 32'(lanes), 32'h3);
    phy_st = 11'h070;
    apb_wr(12'h004, 32'h0); chk("R3 gated closed", 32'(lanes), 32'h3);
    apb_rd(12'h004, '0, '0, d); chk("R3 readback", d, 32'h3);

    // R4 PHY state passthrough
    phy_st = 11'h5A5;
    apb_rd(12'h014, '0, '0, d); chk("R4 phy state", d, 32'h5A5);
    phy_st = 11'h0F0;

    // R8 / R9 test port
    apb_wr(12'h030, 32'hFFFF_FFFE); chk("R8 strobe/clear", {30'b0, strobe, clr}, 32'h2);
    tdout = 8'hC3;
    apb_wr(12'h034, 32'hFFFF_FF5A);
    chk("R9 outputs", {23'b0, asel, tdin}, 32'h15A);
    apb_rd(12'h034, '0, '0, d); chk("R9 readback", d, 32'h0001_C35A);
    apb_rd(12'h030, '0, '0, d); chk("R8 readback", d, 32'h2);

    // R10 unmapped and high addresses
    apb_wr(12'h040, 32'hFFFF_FFFF); apb_wr(12'h128, 32'hFFFF_FFFF);
    apb_rd(12'h028, '0, '0, d); chk("R10 mask untouched", d, 32'h0);
    apb_rd(12'h018, '0, '0, d); chk("R10 unmapped read", d, 32'h0);
    apb_rd(12'h108, '0, '0, d); chk("R10 high address read", d, 32'h0);

    // R5 sticky capture, status writes ignored
    pulse(29'h1000_0001, 24'h80_0001);
    chk("R7 irq after event", 32'(irq), 32'(exp_irq()));
    apb_wr(12'h020, 32'h0); apb_wr(12'h024, 32'hFFFF_FFFF);
    chk("R5 irq held", 32'(irq), 32'h1);
    read_status(0, '0, '0);
    read_status(1, '0, '0);
    chk("R6 irq cleared", 32'(irq), 32'h0);

    // R6 coincident event survives the read
    pulse(29'h0000_0F00, '0);
    read_status(0, 29'h0000_0002, 24'h00_0100);
    chk("R6 coincident irq", 32'(irq), 32'(exp_irq()));
    read_status(0, '0, '0);
    read_status(1, '0, '0);

    // R7 masking
    m1 = 29'h1FFF_FFFF; apb_wr(12'h028, 32'hFFFF_FFFF);
    pulse(29'h0000_0010, '0);
    chk("R7 masked irq", 32'(irq), 32'h0);
    m1 = '0; apb_wr(12'h028, 32'h0);
    chk("R7 unmask raises irq", 32'(irq), 32'h1);
    apb_rd(12'h02C, '0, '0, d); chk("R7 mask2 zero", d, 32'h0);

    // random traffic
    for (int i = 0; i < 400; i++) begin
      int op;
      op = int'($urandom_range(0, 4));
      case (op)
        0: pulse(29'($urandom & $urandom & $urandom), 24'($urandom & $urandom & $urandom));
        1: begin m1 = 29'($urandom | $urandom); apb_wr(12'h028, {3'b111, m1}); end
        2: begin m2 = 24'($urandom | $urandom); apb_wr(12'h02C, {8'hFF, m2}); end
        3: read_status(0, 29'($urandom & $urandom & $urandom & $urandom), 24'($urandom & $urandom & $urandom));
        default: read_status(1, '0, 24'($urandom & $urandom & $urandom & $urandom));
      endcase
      chk("R7 random irq", 32'(irq), 32'(exp_irq()));
    end
    apb_rd(12'h02C, '0, '0, d); chk("R7 mask2 readback", d, {8'b0, m2});
    read_status(0, '0, '0);
    read_status(1, '0, '0);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule